// File: doc/BRIEF.md
# Dual-Issue Dispatch Pairing Gate

This block sits at the end of decode in an in-order processor that can dispatch up to two instructions per cycle. Each cycle it looks at the two oldest decoded instructions. Slot 0 always holds the older one and slot 1 the younger. The block decides whether slot 0 dispatches alone, whether both dispatch together, or whether nothing dispatches. When slot 0 goes alone, the younger instruction is expected to move into slot 0 in the next cycle. Moving it is the job of the surrounding queue.

Each slot presents the following inputs:
- a valid bit;
- a three-bit unit class;
- flags for non-pipelined, microcoded and context-synchronizing instructions.

Slot 0 also presents the low three address bits of its instruction.

Two conditions decide whether a pair is allowed:
- the two unit classes must form a legal combination;
- no special instruction kind may be present that forces single issue.

A microcoded instruction is dispatched on its own and then holds all dispatch for a fixed number of cycles while its first micro-op is fetched from ROM.

The controller has two named states:
- `RUN`: normal pairing decisions are made. The transition `RUN -> ROM_WAIT` is taken when a microcoded slot-0 instruction dispatches.
- `ROM_WAIT`: dispatch is held and the stall request is raised. The transition `ROM_WAIT -> RUN` is taken in the cycle the stall counter expires.

Top module: `dual_dispatch_gate`

## Requirements
- R1: In `RUN`, `go_s0` equals `s0_valid`. With `s0_valid` low nothing dispatches, even if slot 1 is valid.
- R2: `go_s1` is high only when `go_s0` and `s1_valid` are both high and every pairing rule below allows the pair.
- R3: The class codes are 0 fixed-point, 1 load/store, 2 branch, 3 vector/float arithmetic and 4 vector permute or vector/float load/store. Codes 5 to 7 never pair. The following pairs (in either slot order) are illegal; all other pairs among codes 0 to 4 are legal:
  - 0+0
  - 1+1
  - 2+2
  - 3+3
  - 4+4
  - 1 with 4
- R4: A non-pipelined instruction in slot 0 dispatches alone. A non-pipelined instruction in slot 1 may still pair.
- R5: A microcoded instruction in either slot prevents pairing.
- R6: When a microcoded slot-0 instruction dispatches, the next `MC_STALL` cycles (default 7) have `rom_stall` high and both `go` outputs low. Dispatch resumes in the cycle after that.
- R7: A context-synchronizing instruction in either slot prevents pairing.
- R8: A branch-class instruction in slot 0 dispatches alone.
- R9: If `s0_addr_lo` is not zero (slot 0 not at the start of an 8-byte group), slot 0 dispatches alone.
- R10: After reset the state is `RUN` and `rom_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 3 | Slot 0 unit class |
| s0_nonpipe | input | 1 | Slot 0 is non-pipelined |
| s0_ucode | input | 1 | Slot 0 is microcoded |
| s0_sync | input | 1 | Slot 0 is context-synchronizing |
| s0_addr_lo | input | 3 | Low address bits of slot 0 |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 3 | Slot 1 unit class |
| s1_nonpipe | input | 1 | Slot 1 is non-pipelined |
| s1_ucode | input | 1 | Slot 1 is microcoded |
| s1_sync | input | 1 | Slot 1 is context-synchronizing |
| go_s0 | output | 1 | Slot 0 dispatches this cycle |
| go_s1 | output | 1 | Slot 1 dispatches together with slot 0 |
| rom_stall | output | 1 | Dispatch held for a microcode ROM fetch |

## Verification
The assertions assume that the flag and class inputs are meaningful only when the matching valid bit is high. They also assume the inputs are stable across each clock edge. The stall-length check further assumes that no reset arrives in the middle of a `ROM_WAIT` window.

The stimulus changes inputs only at the falling edge and asserts reset only at the start of the run. Random vectors keep the microcoded flag rare, so that `RUN` occupies most cycles and pairing decisions are exercised often. Directed vectors cover each illegal class pair, every single-issue cause, and a full microcode stall window.

// File: rtl/dsp_pair_pkg.sv
package dsp_pair_pkg;
    localparam int CLS_W  = 3;
    localparam int N_CLS  = 5;
    localparam int N_CODE = 1 << CLS_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_FXU  = 3'd0,
        CLS_LSU  = 3'd1,
        CLS_BR   = 3'd2,
        CLS_VAR  = 3'd3,
        CLS_VPLS = 3'd4
    } unit_cls_e;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_ROM_WAIT = 1'b1
    } gate_state_e;

    // Combination legality between two class codes (order independent).
    function automatic logic classes_combine(input int a, input int b);
        if (a >= N_CLS || b >= N_CLS) return 1'b0;
        if (a == b) return 1'b0;
        if ((a == int'(CLS_LSU) && b == int'(CLS_VPLS)) ||
            (b == int'(CLS_LSU) && a == int'(CLS_VPLS))) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/dsp_class_matrix.sv
module dsp_class_matrix
    import dsp_pair_pkg::*;
(
    input  logic [CLS_W-1:0] cls_old,
    input  logic [CLS_W-1:0] cls_young,
    output logic             combo_ok
);
    logic grid [N_CODE][N_CODE];

    for (genvar i = 0; i < N_CODE; i++) begin : g_row
        for (genvar j = 0; j < N_CODE; j++) begin : g_col
            assign grid[i][j] = classes_combine(i, j);
        end
    end

    assign combo_ok = grid[cls_old][cls_young];
endmodule

// File: rtl/dsp_solo_screen.sv
module dsp_solo_screen
    import dsp_pair_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [CLS_W-1:0]  s0_cls,
    input  logic              s0_nonpipe,
    input  logic              s0_ucode,
    input  logic              s0_sync,
    input  logic [ADDR_W-1:0] s0_addr_lo,
    input  logic              s1_ucode,
    input  logic              s1_sync,
    output logic              older_solo,
    output logic              younger_block
);
    logic misaligned;
    logic is_branch;

    assign misaligned    = (s0_addr_lo != '0);
    assign is_branch     = (s0_cls == CLS_BR);
    assign older_solo    = s0_nonpipe | s0_ucode | s0_sync | is_branch | misaligned;
    assign younger_block = s1_ucode | s1_sync;
endmodule

// File: rtl/dsp_rom_timer.sv
module dsp_rom_timer #(
    parameter int MC_STALL = 7,
    localparam int CNT_W   = $clog2(MC_STALL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= CNT_W'(MC_STALL);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dual_dispatch_gate.sv
module dual_dispatch_gate
    import dsp_pair_pkg::*;
#(
    parameter int MC_STALL = 7,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s0_valid,
    input  logic [CLS_W-1:0]  s0_cls,
    input  logic              s0_nonpipe,
    input  logic              s0_ucode,
    input  logic              s0_sync,
    input  logic [ADDR_W-1:0] s0_addr_lo,
    input  logic              s1_valid,
    input  logic [CLS_W-1:0]  s1_cls,
    input  logic              s1_nonpipe,
    input  logic              s1_ucode,
    input  logic              s1_sync,
    output logic              go_s0,
    output logic              go_s1,
    output logic              rom_stall
);
    localparam int LEN_W = $clog2(MC_STALL + 1) + 1;

    gate_state_e state_q, state_d;
    logic combo_ok, older_solo, younger_block, timer_load, timer_expire;

    dsp_class_matrix u_matrix (
        .cls_old  (s0_cls),
        .cls_young(s1_cls),
        .combo_ok (combo_ok)
    );

    dsp_solo_screen #(.ADDR_W(ADDR_W)) u_screen (
        .s0_cls       (s0_cls),
        .s0_nonpipe   (s0_nonpipe),
        .s0_ucode     (s0_ucode),
        .s0_sync      (s0_sync),
        .s0_addr_lo   (s0_addr_lo),
        .s1_ucode     (s1_ucode),
        .s1_sync      (s1_sync),
        .older_solo   (older_solo),
        .younger_block(younger_block)
    );

    dsp_rom_timer #(.MC_STALL(MC_STALL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .expire(timer_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        go_s0      = 1'b0;
        go_s1      = 1'b0;
        rom_stall  = 1'b0;
        timer_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                go_s0 = s0_valid;
                go_s1 = s0_valid & s1_valid & combo_ok & ~older_solo & ~younger_block;
                if (s0_valid && s0_ucode) begin
                    timer_load = 1'b1;
                    state_d    = ST_ROM_WAIT;
                end
            end
            ST_ROM_WAIT: begin
                rom_stall = 1'b1;
                if (timer_expire) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Checker state: length of the current stall window
    logic [LEN_W-1:0] stall_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         stall_len_q <= '0;
        else if (rom_stall) stall_len_q <= stall_len_q + 1'b1;
        else                stall_len_q <= '0;
    end

    // R2
    pair_needs_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_s1 |-> (go_s0 && s1_valid));
    // R1
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |-> (!go_s0 && !go_s1));
    // R6
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_stall |-> (!go_s0 && !go_s1));
    // R6
    ucode_enters_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_s0 && s0_ucode) |=> rom_stall);
    // R6
    stall_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_stall) |-> (stall_len_q == LEN_W'(MC_STALL)));
    // R6
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_stall |-> (stall_len_q < LEN_W'(MC_STALL)));
    // R8
    branch_older_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_cls == CLS_BR) |-> !go_s1);
    // R9
    group_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_s1 |-> (s0_addr_lo == '0));
    // R5
    ucode_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_s1 |-> (!s0_ucode && !s1_ucode));
endmodule

// File: tb/dual_dispatch_gate_tb.sv
module dual_dispatch_gate_tb_top;
    localparam int STALL = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid, s0_nonpipe, s0_ucode, s0_sync;
    logic s1_valid, s1_nonpipe, s1_ucode, s1_sync;
    logic [2:0] s0_cls, s1_cls, s0_addr_lo;
    logic go_s0, go_s1, rom_stall;

    int n_vec = 0;
    int n_bad = 0;
    int stall_left = 0;

    always #2 clk = ~clk;

    dual_dispatch_gate #(.MC_STALL(STALL), .ADDR_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_nonpipe(s0_nonpipe),
        .s0_ucode(s0_ucode), .s0_sync(s0_sync), .s0_addr_lo(s0_addr_lo),
        .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_nonpipe(s1_nonpipe),
        .s1_ucode(s1_ucode), .s1_sync(s1_sync),
        .go_s0(go_s0), .go_s1(go_s1), .rom_stall(rom_stall)
    );

    function automatic bit legal_combo(input logic [2:0] a, input logic [2:0] b);
        if (a > 3'd4 || b > 3'd4) return 1'b0;
        if (a == b) return 1'b0;
        if ({a, b} == {3'd1, 3'd4} || {a, b} == {3'd4, 3'd1}) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit exp_pair();
        if (!s0_valid || !s1_valid) return 1'b0;
        if (s0_nonpipe || s0_ucode || s0_sync) return 1'b0;
        if (s0_cls == 3'd2 || s0_addr_lo != 3'd0) return 1'b0;
        if (s1_ucode || s1_sync) return 1'b0;
        return legal_combo(s0_cls, s1_cls);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic put(input bit v0, input logic [2:0] c0, input bit np0, input bit mc0,
                       input bit sy0, input logic [2:0] al, input bit v1,
                       input logic [2:0] c1, input bit np1, input bit mc1, input bit sy1);
        s0_valid = v0; s0_cls = c0; s0_nonpipe = np0; s0_ucode = mc0;
        s0_sync = sy0; s0_addr_lo = al;
        s1_valid = v1; s1_cls = c1; s1_nonpipe = np1; s1_ucode = mc1; s1_sync = sy1;
    endtask

    // Drive at falling edge (already done by caller), check, advance model.
    task automatic step(input string req);
        bit e_st, e_i0, e_i1;
        #1;
        e_st = (stall_left > 0);
        e_i0 = !e_st && s0_valid;
        e_i1 = e_i0 && exp_pair();
        chk({req, " rom_stall"}, rom_stall, e_st);
        chk({req, " go_s0"}, go_s0, e_i0);
        chk({req, " go_s1"}, go_s1, e_i1);
        if (stall_left > 0) stall_left--;
        else if (e_i0 && s0_ucode) stall_left = STALL;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4711));
        put(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        #1;
        // R10 reset state
        chk("R10 rom_stall in reset", rom_stall, 1'b0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R10 rom_stall after reset", rom_stall, 1'b0);

        // R3 legal pair FXU+LSU
        put(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0); step("R3 fxu+lsu");
        // R3 illegal pairs
        for (int k = 0; k < 5; k++) begin
            put(1, 3'(k), 0, 0, 0, 0, 1, 3'(k), 0, 0, 0); step("R3 same class");
        end
        put(1, 1, 0, 0, 0, 0, 1, 4, 0, 0, 0); step("R3 lsu+vpls");
        put(1, 4, 0, 0, 0, 0, 1, 1, 0, 0, 0); step("R3 vpls+lsu");
        put(1, 3, 0, 0, 0, 0, 1, 4, 0, 0, 0); step("R3 var+vpls");
        put(1, 6, 0, 0, 0, 0, 1, 0, 0, 0, 0); step("R3 undefined code");
        // R1 slot 0 empty
        put(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0); step("R1 empty slot0");
        // R2 slot 1 empty
        put(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); step("R2 empty slot1");
        // R4 non-pipelined
        put(1, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0); step("R4 np slot0");
        put(1, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0); step("R4 np slot1");
        // R7 sync
        put(1, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0); step("R7 sync slot0");
        put(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1); step("R7 sync slot1");
        // R8 branch in slot 0, and in slot 1
        put(1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0); step("R8 branch slot0");
        put(1, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0); step("R8 branch slot1");
        // R9 misaligned
        put(1, 0, 0, 0, 0, 3'd4, 1, 1, 0, 0, 0); step("R9 misaligned");
        // R5 microcode in slot 1
        put(1, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0); step("R5 ucode slot1");
        // R5 R6 microcode in slot 0, then full stall window
        put(1, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0); step("R5 ucode slot0");
        put(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        for (int k = 0; k < STALL; k++) step("R6 stall window");
        step("R6 resume");

        // Random section
        for (int n = 0; n < 3000; n++) begin
            put($urandom_range(0, 7) != 0, 3'($urandom_range(0, 5)),
                $urandom_range(0, 9) == 0, $urandom_range(0, 31) == 0,
                $urandom_range(0, 15) == 0,
                ($urandom_range(0, 3) == 0) ? 3'd4 : 3'd0,
                $urandom_range(0, 5) != 0, 3'($urandom_range(0, 5)),
                $urandom_range(0, 9) == 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 15) == 0);
            step("R3 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule